// File: doc/BRIEF.md
# Whole-Line Write Coalescing Detector

This block sits beside one outstanding cache-miss entry and watches every request that gets merged into that entry. It decides whether the merged requests are all plain, mergeable writes and whether together they touch every byte of the cache line. When both are true, the miss can be sent without fetching the line's old contents, because the fill would overwrite all of it anyway.

Each request brings a write flag, a vector of attribute bits, a byte offset within the line and a size in bytes. The block keeps one coverage bit per byte of the line and a single "only writes" flag. It drives a live whole-line indication. It also holds a registered copy of that indication, taken on the cycle the miss is issued. The fill logic uses that copy, because requests can keep merging into the entry after the miss has left.

Top module: `wlw_detector`

## Requirements
- R1: While `rst` is high at a rising clock edge, the coverage bitmap is cleared and the only-writes flag is set. After that edge `whole_line` and `whole_line_issued` are both 0.
- R2: An accepted request keeps the entry eligible only if `req_write` is 1 and every bit of `req_attr` is 0. A read, or a write with any attribute bit set (uncacheable, strict order, mapped register, privileged, exclusive pair, swap, conditional swap, secure), clears the only-writes flag.
- R3: Once cleared, the only-writes flag stays clear until the next reset, so `whole_line` stays 0 whatever writes follow.
- R4: An accepted eligible request sets the coverage bits for bytes `req_offset` up to `req_offset + req_size - 1`. A size of 0 sets none. Bits already set stay set.
- R5: Bytes past the end of the line (index `LINE_BYTES` or more) are dropped. They do not wrap to the start of the line.
- R6: `whole_line` is 1 exactly when the only-writes flag is set and every coverage bit is set.
- R7: While `whole_line` is 1, accepted requests of any kind leave the flag and the bitmap unchanged, so `whole_line` stays 1 until reset.
- R8: At a rising edge with `issue` high, `whole_line_issued` takes the value `whole_line` had before that edge. At any other edge outside reset it keeps its value.
- R9: A request updates the state at the first rising edge where `req_valid` is 1. At an edge where `req_valid` is 0, the request fields have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset / entry init |
| req_valid | input | 1 | A request is being merged this cycle |
| req_write | input | 1 | Request is a write |
| req_attr | input | ATTR_W | Attribute bits; any set bit makes the request non-mergeable |
| req_offset | input | $clog2(LINE_BYTES) | First byte of the request within the line |
| req_size | input | $clog2(LINE_BYTES+1) | Request length in bytes |
| issue | input | 1 | The miss is sent this cycle; capture the snapshot |
| whole_line | output | 1 | Live whole-line indication |
| whole_line_issued | output | 1 | Whole-line value captured at issue |

## Verification
Several properties are checked by assertions on every cycle:
- the only-writes flag never recovers without a reset;
- coverage bits are never lost;
- the state is frozen once the line is whole;
- a non-mergeable request always clears eligibility;
- the snapshot only moves on an issue edge, and then copies the prior live value.

Other behaviour can only be shown by the bench's scenarios:
- the exact byte ranges set by each offset and size;
- clipping at the end of the line rather than wrapping;
- the line turning whole only when the last byte is filled;
- the snapshot staying unchanged while later merges change the live flag.

The bench checks these against its own byte-level model.

// File: rtl/wlw_pkg.sv
package wlw_pkg;

   // Attribute bit positions: any set bit disqualifies a request from merging.
   localparam int ATTR_UNCACHED   = 0;
   localparam int ATTR_STRICT     = 1;
   localparam int ATTR_MAPPED_REG = 2;
   localparam int ATTR_PRIV       = 3;
   localparam int ATTR_EXCL_PAIR  = 4;
   localparam int ATTR_SWAP       = 5;
   localparam int ATTR_SWAP_COND  = 6;
   localparam int ATTR_SECURE     = 7;
   localparam int ATTR_COUNT      = 8;

   // Byte-mask construction variants.
   typedef enum logic [0:0] {
      MASK_COMPARE = 1'b0,
      MASK_SHIFT   = 1'b1
   } mask_impl_e;

endpackage

// File: rtl/wlw_req_qual.sv
module wlw_req_qual #(
   parameter int ATTR_W = wlw_pkg::ATTR_COUNT
) (
   input  logic              req_valid,
   input  logic              req_write,
   input  logic [ATTR_W-1:0] req_attr,
   output logic              accept,
   output logic              mergeable
);

   if (ATTR_W < 1) begin : g_bad_attr
      $error("wlw_req_qual: ATTR_W must be at least 1");
   end

   always_comb begin
      accept    = req_valid;
      mergeable = req_write && (req_attr == '0);
   end

endmodule

// File: rtl/wlw_byte_mask.sv
module wlw_byte_mask #(
   parameter int                  LINE_BYTES = 64,
   parameter wlw_pkg::mask_impl_e IMPL       = wlw_pkg::MASK_COMPARE,
   localparam int OFF_W  = $clog2(LINE_BYTES),
   localparam int SIZE_W = $clog2(LINE_BYTES + 1)
) (
   input  logic [OFF_W-1:0]      offset,
   input  logic [SIZE_W-1:0]     size,
   output logic [LINE_BYTES-1:0] mask
);

   localparam int SUM_W = SIZE_W + 1;

   if (IMPL == wlw_pkg::MASK_COMPARE) begin : g_cmp
      logic [SUM_W-1:0] end_excl;
      always_comb end_excl = SUM_W'(offset) + SUM_W'(size);
      for (genvar b = 0; b < LINE_BYTES; b++) begin : g_byte
         always_comb
            mask[b] = (SUM_W'(b) >= SUM_W'(offset)) && (SUM_W'(b) < end_excl);
      end
   end else begin : g_shift
      logic [SIZE_W-1:0]       size_clamped;
      logic [LINE_BYTES-1:0]   ones;
      logic [2*LINE_BYTES-1:0] wide;
      always_comb begin
         size_clamped = (size > SIZE_W'(LINE_BYTES)) ? SIZE_W'(LINE_BYTES) : size;
         ones = {LINE_BYTES{1'b1}} >> (LINE_BYTES - int'(size_clamped));
         if (size_clamped == '0) ones = '0;
         wide = {{LINE_BYTES{1'b0}}, ones} << offset;
         mask = wide[LINE_BYTES-1:0];
      end
   end

endmodule

// File: rtl/wlw_cover_track.sv
module wlw_cover_track #(
   parameter int LINE_BYTES = 64
) (
   input  logic                  clk,
   input  logic                  rst,
   input  logic                  upd,
   input  logic                  mergeable,
   input  logic [LINE_BYTES-1:0] mask,
   output logic                  whole
);

   logic                  only_wr_q;
   logic [LINE_BYTES-1:0] cov_q;
   logic                  only_wr_n;
   logic                  full;

   always_comb begin
      full      = &cov_q;
      whole     = only_wr_q && full;
      only_wr_n = only_wr_q && mergeable;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         only_wr_q <= 1'b1;
         cov_q     <= '0;
      end else if (upd && !whole) begin
         only_wr_q <= only_wr_n;
         if (only_wr_n) cov_q <= cov_q | mask;
      end
   end

   // R1: init state after reset
   assert_reset_init_R1: assert property (@(posedge clk)
      rst |=> (only_wr_q && cov_q == '0));

   // R2: non-mergeable accepted request clears eligibility
   assert_nonmerge_clears_R2: assert property (@(posedge clk) disable iff (rst)
      (upd && !mergeable && !whole) |=> !only_wr_q);

   // R3: eligibility never comes back without reset
   assert_sticky_only_wr_R3: assert property (@(posedge clk) disable iff (rst)
      !only_wr_q |=> !only_wr_q);

   // R4: coverage bits are never lost
   assert_cov_monotonic_R4: assert property (@(posedge clk) disable iff (rst)
      !rst |=> ((cov_q & $past(cov_q)) == $past(cov_q)));

   // R7: state frozen once the line is whole
   assert_frozen_whole_R7: assert property (@(posedge clk) disable iff (rst)
      whole |=> (whole && $stable(cov_q) && $stable(only_wr_q)));

   // R9: no request, no change
   assert_idle_stable_R9: assert property (@(posedge clk) disable iff (rst)
      !upd |=> ($stable(cov_q) && $stable(only_wr_q)));

endmodule

// File: rtl/wlw_snapshot.sv
module wlw_snapshot (
   input  logic clk,
   input  logic rst,
   input  logic issue,
   input  logic live,
   output logic snap
);

   always_ff @(posedge clk) begin
      if (rst)        snap <= 1'b0;
      else if (issue) snap <= live;
   end

   // R8: capture on issue, hold otherwise
   assert_snap_capture_R8: assert property (@(posedge clk) disable iff (rst)
      issue |=> (snap == $past(live)));
   assert_snap_hold_R8: assert property (@(posedge clk) disable iff (rst)
      !issue |=> $stable(snap));

endmodule

// File: rtl/wlw_detector.sv
module wlw_detector #(
   parameter int                  LINE_BYTES = 64,
   parameter int                  ATTR_W     = wlw_pkg::ATTR_COUNT,
   parameter wlw_pkg::mask_impl_e MASK_IMPL  = wlw_pkg::MASK_COMPARE,
   localparam int OFF_W  = $clog2(LINE_BYTES),
   localparam int SIZE_W = $clog2(LINE_BYTES + 1)
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              req_valid,
   input  logic              req_write,
   input  logic [ATTR_W-1:0] req_attr,
   input  logic [OFF_W-1:0]  req_offset,
   input  logic [SIZE_W-1:0] req_size,
   input  logic              issue,
   output logic              whole_line,
   output logic              whole_line_issued
);

   if (LINE_BYTES < 2 || (LINE_BYTES & (LINE_BYTES - 1)) != 0) begin : g_bad_line
      $error("wlw_detector: LINE_BYTES must be a power of two >= 2");
   end

   logic                  accept;
   logic                  mergeable;
   logic [LINE_BYTES-1:0] mask;

   wlw_req_qual #(.ATTR_W(ATTR_W)) u_qual (
      .req_valid (req_valid),
      .req_write (req_write),
      .req_attr  (req_attr),
      .accept    (accept),
      .mergeable (mergeable)
   );

   wlw_byte_mask #(.LINE_BYTES(LINE_BYTES), .IMPL(MASK_IMPL)) u_mask (
      .offset (req_offset),
      .size   (req_size),
      .mask   (mask)
   );

   wlw_cover_track #(.LINE_BYTES(LINE_BYTES)) u_track (
      .clk       (clk),
      .rst       (rst),
      .upd       (accept),
      .mergeable (mergeable),
      .mask      (mask),
      .whole     (whole_line)
   );

   wlw_snapshot u_snap (
      .clk   (clk),
      .rst   (rst),
      .issue (issue),
      .live  (whole_line),
      .snap  (whole_line_issued)
   );

   // R6: a read arriving while not whole can never produce whole next cycle
   assert_read_not_whole_R6: assert property (@(posedge clk) disable iff (rst)
      (req_valid && !req_write && !whole_line) |=> !whole_line);

endmodule

// File: tb/tb_wlw_detector.sv
module tb_wlw_detector;

   localparam int LINE   = 64;
   localparam int ATTR_W = 8;
   localparam int OFF_W  = $clog2(LINE);
   localparam int SIZE_W = $clog2(LINE + 1);

   logic              clk = 1'b0;
   logic              rst = 1'b1;
   logic              req_valid = 1'b0;
   logic              req_write = 1'b0;
   logic [ATTR_W-1:0] req_attr = '0;
   logic [OFF_W-1:0]  req_offset = '0;
   logic [SIZE_W-1:0] req_size = '0;
   logic              issue = 1'b0;
   logic              whole_line;
   logic              whole_line_issued;

   int n_tests = 0;
   int n_fail  = 0;
   bit finished = 0;

   // bench model
   logic [LINE-1:0] m_cov;
   bit              m_ow;
   bit              m_snap;

   always #5 clk = ~clk;

   wlw_detector #(.LINE_BYTES(LINE), .ATTR_W(ATTR_W)) dut (
      .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
      .req_attr(req_attr), .req_offset(req_offset), .req_size(req_size),
      .issue(issue), .whole_line(whole_line), .whole_line_issued(whole_line_issued)
   );

   function automatic logic [LINE-1:0] bytes_of(int off, int sz);
      logic [LINE-1:0] r = '0;
      for (int i = 0; i < LINE; i++)
         if (i >= off && i < off + sz) r[i] = 1'b1;
      return r;
   endfunction

   function automatic bit model_whole();
      return m_ow && (&m_cov);
   endfunction

   task automatic check(input bit act, input bit exp, input string tag);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual=%0b expected=%0b", tag, act, exp);
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst = 1'b1; req_valid = 1'b0; issue = 1'b0;
      @(posedge clk); #1;
      m_cov = '0; m_ow = 1'b1; m_snap = 1'b0;
      @(negedge clk);
      rst = 1'b0;
   endtask

   // drive one cycle, advance model, sample after the edge
   task automatic step(input bit v, input bit w, input logic [ATTR_W-1:0] a,
                       input int off, input int sz, input bit iss);
      bit n_ow;
      logic [LINE-1:0] n_cov;
      bit n_snap;
      @(negedge clk);
      req_valid = v; req_write = w; req_attr = a;
      req_offset = OFF_W'(off); req_size = SIZE_W'(sz); issue = iss;
      n_ow = m_ow; n_cov = m_cov; n_snap = m_snap;
      if (iss) n_snap = model_whole();
      if (v && !model_whole()) begin
         n_ow = m_ow && w && (a == '0);
         if (n_ow) n_cov = m_cov | bytes_of(off, sz);
      end
      @(posedge clk); #1;
      m_ow = n_ow; m_cov = n_cov; m_snap = n_snap;
      req_valid = 1'b0; issue = 1'b0;
   endtask

   initial begin
      #2_000_000;
      if (!finished) begin
         n_tests++; n_fail++;
         $display("FAIL watchdog: actual=timeout expected=done");
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd1234));
      m_cov = '0; m_ow = 1'b1; m_snap = 1'b0;

      // R1: reset state
      do_reset();
      check(whole_line, 1'b0, "R1 whole after reset");
      check(whole_line_issued, 1'b0, "R1 snap after reset");

      // R4: two halves make the line whole (R6)
      step(1, 1, '0, 0, 32, 0);
      check(whole_line, 1'b0, "R4 half covered");
      step(1, 1, '0, 32, 32, 0);
      check(whole_line, 1'b1, "R6 both halves");

      // R7: read after whole does not change it
      step(1, 0, '0, 0, 4, 0);
      check(whole_line, 1'b1, "R7 read after whole");
      step(1, 1, 8'h01, 0, 4, 0);
      check(whole_line, 1'b1, "R7 attr write after whole");

      // R2: read kills eligibility; R3: full write later does not revive
      do_reset();
      step(1, 0, '0, 0, 1, 0);
      step(1, 1, '0, 0, 64, 0);
      check(whole_line, 1'b0, "R2 read then full write");
      step(1, 1, '0, 0, 64, 0);
      check(whole_line, 1'b0, "R3 sticky after read");

      // R2: each attribute bit alone disqualifies
      for (int b = 0; b < ATTR_W; b++) begin
         do_reset();
         step(1, 1, ATTR_W'(1) << b, 0, 8, 0);
         step(1, 1, '0, 0, 64, 0);
         check(whole_line, 1'b0, $sformatf("R2 attr bit %0d", b));
      end

      // R5: clipping past the line end, no wrap
      do_reset();
      step(1, 1, '0, 60, 16, 0);
      step(1, 1, '0, 4, 56, 0);
      check(whole_line, 1'b0, "R5 no wrap to byte 0");
      step(1, 1, '0, 0, 4, 0);
      check(whole_line, 1'b1, "R5 low bytes complete");

      // R4: size zero sets nothing
      do_reset();
      step(1, 1, '0, 0, 63, 0);
      step(1, 1, '0, 63, 0, 0);
      check(whole_line, 1'b0, "R4 size zero");
      step(1, 1, '0, 63, 1, 0);
      check(whole_line, 1'b1, "R4 last byte");

      // R9: request fields ignored without valid
      do_reset();
      step(0, 1, '0, 0, 64, 0);
      check(whole_line, 1'b0, "R9 no valid no cover");
      step(0, 0, 8'hFF, 0, 1, 0);
      step(1, 1, '0, 0, 64, 0);
      check(whole_line, 1'b1, "R9 invalid read ignored");

      // R8: snapshot capture and hold
      step(0, 0, '0, 0, 0, 1);
      check(whole_line_issued, 1'b1, "R8 capture whole");
      do_reset();
      step(1, 1, '0, 0, 32, 1);
      check(whole_line_issued, 1'b0, "R8 capture not whole");
      step(1, 1, '0, 32, 32, 0);
      check(whole_line, 1'b1, "R6 whole after issue");
      check(whole_line_issued, 1'b0, "R8 snap holds after late merge");

      // random phase
      do_reset();
      for (int it = 0; it < 3000; it++) begin
         int r, off, sz;
         bit w;
         logic [ATTR_W-1:0] a;
         r = int'($urandom_range(0, 99));
         if (r < 4) begin
            do_reset();
            check(whole_line, 1'b0, "R1 random reset");
            continue;
         end
         w   = ($urandom_range(0, 19) != 0);
         a   = ($urandom_range(0, 29) == 0) ? ATTR_W'(1) << $urandom_range(0, ATTR_W-1) : '0;
         off = int'($urandom_range(0, LINE-1));
         sz  = int'($urandom_range(0, 24));
         step($urandom_range(0, 4) != 0, w, a, off, sz, $urandom_range(0, 9) == 0);
         check(whole_line, model_whole(), "R6 random live");
         check(whole_line_issued, m_snap, "R8 random snapshot");
      end

      finished = 1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule